// File: doc/BRIEF.md
# Hamming Single-Bit ECC Corrector

This block takes two 24-bit Hamming check codes for one 512-byte flash data block. One code was stored in the spare area of the page. The other was recomputed over the data as it was read back. The block XORs them into a syndrome and sorts the result into four classes:
- clean;
- a single data bit in error, which can be corrected;
- a fault confined to the stored code;
- an uncorrectable error.

For a correctable error it reports which byte and which bit to flip. A fix-up port lets the surrounding buffer logic present any byte together with its index. The byte comes back with the faulty bit inverted when it is the one flagged.

The verdict is registered on the clock edge that samples a valid strobe, and a one-cycle done pulse comes with it. The verdict then holds until the next strobe. An optional mode treats an all-ones stored code as a page that was never protected, and reports it as clean.

Top module: `hamming_fix`

## Requirements
- R1: The syndrome is stored_code XOR calc_code, with d0 = bits [7:0], d1 = bits [15:8] and d2 = bits [23:16]. A zero syndrome gives status 2'b00.
- R2: The status and location register on the rising edge where chk_valid is 1. done is 1 for exactly the following cycle. Status and location hold until the next strobe.
- R3: When stored_code is 24'hFFFFFF and ign_blank is 1, the status is 2'b00 whatever the syndrome is. When ign_blank is 0, the same inputs are classified normally.
- R4: If every syndrome byte d satisfies ((d ^ (d>>1)) & 8'h55) == 8'h55, the status is 2'b01. err_bit is {d2[7],d2[5],d2[3]}. err_byte is {d2[1],d1[7],d1[5],d1[3],d1[1],d0[7],d0[5],d0[3],d0[1]}. Both are written MSB first.
- R5: Otherwise, a syndrome with exactly one bit set gives status 2'b10 (the fault is in the stored code), with err_byte and err_bit at 0.
- R6: Any other nonzero syndrome gives status 2'b11, with err_byte and err_bit at 0.
- R7: fix_dout equals fix_din with bit err_bit inverted when the status is 2'b01 and fix_idx equals err_byte. In every other case fix_dout equals fix_din. The path is combinational.
- R8: After reset the status is 2'b00, done is 0, and err_byte and err_bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_valid | input | 1 | Strobe: sample both codes this cycle |
| ign_blank | input | 1 | Treat an all-ones stored code as clean |
| stored_code | input | 24 | Code read from the spare area |
| calc_code | input | 24 | Code computed over the data |
| status | output | 2 | 00 clean, 01 data corrected, 10 code-only fault, 11 uncorrectable |
| done | output | 1 | One-cycle pulse after each strobe |
| err_byte | output | 9 | Index of the byte to correct |
| err_bit | output | 3 | Bit within that byte to correct |
| fix_idx | input | 9 | Index of the byte presented for fix-up |
| fix_din | input | 8 | Byte presented for fix-up |
| fix_dout | output | 8 | Byte after correction |

## Verification
The block is driven with the following syndromes:
- Equal codes confirm that the clean path is taken.
- Correctable syndromes built for the first byte, the last byte and a mixed byte index show that each address bit comes from its own odd syndrome position.
- A single-bit syndrome separates a fault in the stored code from a data fault.
- A two-bit syndrome lands in the uncorrectable class.

An all-ones stored code is applied with the blank option on and with it off. With it off, the same inputs must fall back to normal classification, which tests the priority order. The fix-up port is tried with a matching index, a differing index and a non-corrected status, to show that the inversion happens only on the flagged byte.

// File: rtl/hamming_fix.sv
module hamming_fix #(
  parameter int CW = 24,
  parameter int BW = 9,
  parameter int KW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_valid,
  input  logic          ign_blank,
  input  logic [CW-1:0] stored_code,
  input  logic [CW-1:0] calc_code,
  output logic [1:0]    status,
  output logic          done,
  output logic [BW-1:0] err_byte,
  output logic [KW-1:0] err_bit,
  input  logic [BW-1:0] fix_idx,
  input  logic [7:0]    fix_din,
  output logic [7:0]    fix_dout
);
  localparam logic [1:0] ST_OK   = 2'b00;
  localparam logic [1:0] ST_FIX  = 2'b01;
  localparam logic [1:0] ST_CODE = 2'b10;
  localparam logic [1:0] ST_BAD  = 2'b11;

  logic [CW-1:0] syn;
  logic [7:0]    d0, d1, d2;
  logic          pairs_ok, one_hot, blank;
  logic [1:0]    cls;
  logic [BW-1:0] loc_byte;
  logic [KW-1:0] loc_bit;

  assign syn = stored_code ^ calc_code;
  assign d0  = syn[7:0];
  assign d1  = syn[15:8];
  assign d2  = syn[23:16];

  assign pairs_ok = (((d0 ^ (d0 >> 1)) & 8'h55) == 8'h55) &&
                    (((d1 ^ (d1 >> 1)) & 8'h55) == 8'h55) &&
                    (((d2 ^ (d2 >> 1)) & 8'h55) == 8'h55);
  assign one_hot  = (syn != '0) && ((syn & (syn - 1'b1)) == '0);
  assign blank    = ign_blank && (stored_code == {CW{1'b1}});

  assign loc_bit  = {d2[7], d2[5], d2[3]};
  assign loc_byte = {d2[1], d1[7], d1[5], d1[3], d1[1], d0[7], d0[5], d0[3], d0[1]};

  always_comb begin
    if (syn == '0)     cls = ST_OK;
    else if (blank)    cls = ST_OK;
    else if (pairs_ok) cls = ST_FIX;
    else if (one_hot)  cls = ST_CODE;
    else               cls = ST_BAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= ST_OK;
      done     <= 1'b0;
      err_byte <= '0;
      err_bit  <= '0;
    end else begin
      done <= chk_valid;
      if (chk_valid) begin
        status   <= cls;
        err_byte <= (cls == ST_FIX) ? loc_byte : '0;
        err_bit  <= (cls == ST_FIX) ? loc_bit  : '0;
      end
    end
  end

  assign fix_dout = ((status == ST_FIX) && (fix_idx == err_byte)) ?
                    (fix_din ^ (8'h01 << err_bit)) : fix_din;
endmodule

module hamming_fix_chk #(
  parameter int CW = 24,
  parameter int BW = 9,
  parameter int KW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chk_valid,
  input logic          ign_blank,
  input logic [CW-1:0] stored_code,
  input logic [CW-1:0] calc_code,
  input logic [1:0]    status,
  input logic          done,
  input logic [BW-1:0] err_byte,
  input logic [KW-1:0] err_bit,
  input logic [BW-1:0] fix_idx,
  input logic [7:0]    fix_din,
  input logic [7:0]    fix_dout
);
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> done); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !done); // R2
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> ($stable(status) && $stable(err_byte) && $stable(err_bit))); // R2
  AST_ZERO_SYN: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && stored_code == calc_code) |=> status == 2'b00); // R1
  AST_BLANK_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && ign_blank && stored_code == {CW{1'b1}}) |=> status == 2'b00); // R3
  AST_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !ign_blank && $countones(stored_code ^ calc_code) == 1) |=> status == 2'b10); // R5
  AST_LOC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b01 |-> (err_byte == '0 && err_bit == '0)); // R6
  AST_FIX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'b01 || fix_idx != err_byte) |-> fix_dout == fix_din); // R7
  AST_FIX_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b01 && fix_idx == err_byte) |-> $countones(fix_dout ^ fix_din) == 1); // R7
endmodule

bind hamming_fix hamming_fix_chk #(.CW(CW), .BW(BW), .KW(KW)) u_chk (.*);

// File: tb/sim_hamming_fix.sv
`timescale 1ns/1ps
module sim_hamming_fix;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_valid = 1'b0;
  logic        ign_blank = 1'b0;
  logic [23:0] stored_code = '0;
  logic [23:0] calc_code = '0;
  logic [1:0]  status;
  logic        done;
  logic [8:0]  err_byte;
  logic [2:0]  err_bit;
  logic [8:0]  fix_idx = '0;
  logic [7:0]  fix_din = '0;
  logic [7:0]  fix_dout;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hamming_fix u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mk_syn(input logic [8:0] b, input logic [2:0] k);
    logic [11:0] a;
    logic [23:0] s;
    a = {k, b};
    for (int i = 0; i < 12; i++) begin
      s[2*i+1] = a[i];
      s[2*i]   = ~a[i];
    end
    return s;
  endfunction

  task automatic strobe(input logic [23:0] st, input logic [23:0] cc, input logic ign);
    @(negedge clk);
    stored_code = st; calc_code = cc; ign_blank = ign; chk_valid = 1'b1;
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R8 status", status, 0);
    check("R8 done", done, 0);
    check("R8 loc", {err_byte, err_bit}, 0);
  endtask

  task automatic t_clean;
    strobe(24'h3C5A96, 24'h3C5A96, 1'b0);
    check("R1 status", status, 0);
    check("R2 done", done, 1);
    @(negedge clk);
    check("R2 done drop", done, 0);
    check("R2 hold", status, 0);
  endtask

  task automatic t_correct(input logic [8:0] b, input logic [2:0] k);
    logic [23:0] cc;
    cc = 24'hA1B2C3;
    strobe(cc ^ mk_syn(b, k), cc, 1'b0);
    check("R4 status", status, 1);
    check("R4 byte", err_byte, b);
    check("R4 bit", err_bit, k);
    fix_idx = b; fix_din = 8'h5A;
    #1 check("R7 hit", fix_dout, 8'h5A ^ (8'h01 << k));
    fix_idx = b ^ 9'h001;
    #1 check("R7 miss", fix_dout, 8'h5A);
  endtask

  task automatic t_code_only;
    strobe(24'h123456, 24'h123456 ^ 24'h800000, 1'b0);
    check("R5 status", status, 2);
    check("R5 loc", {err_byte, err_bit}, 0);
    fix_idx = 9'd0; fix_din = 8'hC3;
    #1 check("R7 pass on R5", fix_dout, 8'hC3);
  endtask

  task automatic t_uncorr;
    strobe(24'h000003, 24'h000000, 1'b0);
    check("R6 status", status, 3);
    check("R6 loc", {err_byte, err_bit}, 0);
  endtask

  task automatic t_blank;
    strobe(24'hFFFFFF, 24'hFFFFFF ^ mk_syn(9'd7, 3'd2), 1'b1);
    check("R3 blank on", status, 0);
    strobe(24'hFFFFFF, 24'hFFFFFE, 1'b0);
    check("R3 blank off", status, 2);
    strobe(24'hFFFFFF, 24'h00F00F, 1'b1);
    check("R3 blank any", status, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_clean();
    t_correct(9'd0, 3'd0);
    t_correct(9'd511, 3'd7);
    t_correct(9'h155, 3'd5);
    t_code_only();
    t_uncorr();
    t_blank();
    t_clean();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule